// File: doc/BRIEF.md
# Protection Tuple Inserter

This block sits in the write path of a storage controller and fills in an 8-byte protection tuple for every logical block when the controller generates protection information for the host. A command is started by pulsing `start` with the application tag, the starting reference tag, the protection type, the tuple placement option, the check flags, the low 32 bits of the starting block address and the block count. The block first screens the command against the protection rules. A rejected command produces one `done` pulse with `rej` set and never touches the stream.

An accepted normal write then passes a byte stream through. Each block is `DATA_BYTES` data bytes followed by `META_BYTES` metadata bytes. While data and any metadata ahead of the tuple go by, a 16-bit guard CRC builds up. The tuple bytes that arrive are replaced with the guard, the application tag and the reference tag. All other bytes leave unchanged. In the zero-fill mode nothing is taken from the input. Only metadata is produced for each block: zeros, with the two tag fields filled in when generation is on.

Both byte ports use valid/ready. In a normal write the path is combinational: `out_valid` follows `in_valid`, `in_ready` follows `out_ready`, and a byte moves only when both sides agree in the same cycle. In zero-fill mode `out_valid` stays high and `out_data` holds steady while `out_ready` is low. The control pins (`start`, `busy`, `done`, `rej`, `dnr`) are plain levels and pulses.

Top module: `pi_tuple_gen`

## Requirements
- R1: After reset `busy`, `done`, `out_valid` and `in_ready` are all low.
- R2: The guard is a CRC-16, MSB-first, with polynomial 0x8BB7, starting from zero at each block. It covers the block's data bytes and then the metadata bytes that come before the tuple.
- R3: With `cmd_front`=1 the tuple occupies metadata offsets 0..7. Otherwise it occupies offsets META_BYTES-8..META_BYTES-1. Data bytes and metadata bytes outside the tuple are output unchanged.
- R4: The tuple is big-endian in this order: guard (2 bytes), then application tag (2 bytes), then reference tag (4 bytes).
- R5: The reference tag of the first block is `cmd_rtag`. It rises by one after each block, except that it stays constant when `cmd_ptype`=3. Types are encoded 0 none, 1, 2 and 3.
- R6: `out_last` is high on the last metadata byte of each block. A normal block carries DATA_BYTES+META_BYTES bytes and a zero-fill block carries META_BYTES bytes.
- R7: In a normal write `in_ready` equals `out_ready` while busy. In zero-fill mode a stalled output keeps `out_valid` high and `out_data` stable.
- R8: With `cmd_gen`=0 a normal write passes every byte through unchanged.
- R9: With `cmd_zeroes`=1 and any bit of `cmd_chk` set, the command is rejected with `dnr`=1 and no byte is emitted.
- R10: Zero-fill with `cmd_gen`=1 emits zero metadata in which only the tag fields carry values. The guard field stays zero. With `cmd_gen`=0 all bytes are zero. `in_ready` stays low throughout.
- R11: For type 1 with `cmd_chk[2]` (reference check) set, the command is rejected with `dnr`=1 when `cmd_slba` differs from `cmd_rtag`, and accepted when they match.
- R12: For type 3 with `cmd_chk[2]` set, a normal write is rejected with `dnr`=0.
- R13: `done` is a one-cycle pulse. It comes one cycle after the accepting `start` for a rejection, or one cycle after the last byte handshake. A `start` that arrives while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command start pulse, sampled when idle |
| cmd_zeroes | input | 1 | Zero-fill mode |
| cmd_gen | input | 1 | Generate tuples on behalf of the host |
| cmd_chk | input | 3 | Check flags: bit2 reference, bit1 application, bit0 guard |
| cmd_ptype | input | 2 | Protection type 0..3 |
| cmd_front | input | 1 | Tuple at metadata front (1) or tail (0) |
| cmd_slba | input | 32 | Low 32 bits of the starting block address |
| cmd_rtag | input | 32 | Initial reference tag |
| cmd_atag | input | 16 | Application tag |
| cmd_nblk | input | NBLK_W | Block count minus one |
| busy | output | 1 | Command streaming |
| done | output | 1 | Command finished pulse |
| rej | output | 1 | Last command rejected (valid with done) |
| dnr | output | 1 | Do-not-retry qualifier of the rejection |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream ready |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Last byte of a block |

## Verification
Two things can fall in the same cycle: the handshake of a block's final byte, and the reference-tag update and CRC restart for the next block. In the last block, that same handshake also produces the `done` pulse. The bench drives short multi-block commands with random input gaps and a random `out_ready`, so the block boundary is hit both while stalled and while flowing. It then compares every byte of the following block against a model that restarts the CRC and steps the tag on its own. A second collision, a `start` arriving mid-stream, is provoked on purpose. It is judged by the stream staying correct and exactly one `done` appearing.

// File: rtl/pi_gen_pkg.sv
package pi_gen_pkg;

  localparam logic [15:0] GUARD_POLY  = 16'h8BB7;
  localparam int          TUPLE_BYTES = 8;

  typedef enum logic [1:0] {
    PT_NONE = 2'd0,
    PT_T1   = 2'd1,
    PT_T2   = 2'd2,
    PT_T3   = 2'd3
  } prot_type_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_e;

  // One entry of the byte-wise CRC lookup: the remainder of idx<<8.
  function automatic logic [15:0] crc_tbl_entry(input logic [7:0] idx,
                                                input logic [15:0] poly);
    logic [15:0] c;
    c = {idx, 8'h00};
    for (int b = 0; b < 8; b++) begin
      if (c[15]) c = {c[14:0], 1'b0} ^ poly;
      else       c = {c[14:0], 1'b0};
    end
    return c;
  endfunction

endpackage

// File: rtl/pi_crc16_acc.sv
module pi_crc16_acc
  import pi_gen_pkg::*;
#(
  parameter logic [15:0] POLY = GUARD_POLY
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [15:0] crc
);

  logic [15:0] tbl [256];

  for (genvar g = 0; g < 256; g++) begin : g_tbl
    assign tbl[g] = crc_tbl_entry(8'(g), POLY);
  end

  logic [7:0] idx;
  assign idx = crc[15:8] ^ din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc <= '0;
    else if (clr) crc <= '0;
    else if (en)  crc <= {crc[7:0], 8'h00} ^ tbl[idx];
  end

  // The sequencer never asks for a restart and a byte in the same cycle.
  assert_no_clr_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(clr && en));

endmodule

// File: rtl/pi_cmd_screen.sv
module pi_cmd_screen
  import pi_gen_pkg::*;
(
  input  logic        zeroes,
  input  logic [2:0]  chk,
  input  prot_type_e  ptype,
  input  logic [31:0] slba,
  input  logic [31:0] rtag,
  output logic        reject,
  output logic        dnr
);

  always_comb begin
    reject = 1'b0;
    dnr    = 1'b0;
    if (zeroes) begin
      if (|chk) begin
        reject = 1'b1;
        dnr    = 1'b1;
      end
    end else if (ptype == PT_T1 && chk[2] && slba != rtag) begin
      reject = 1'b1;
      dnr    = 1'b1;
    end else if (ptype == PT_T3 && chk[2]) begin
      reject = 1'b1;
      dnr    = 1'b0;
    end
  end

endmodule

// File: rtl/pi_tuple_mux.sv
module pi_tuple_mux
  import pi_gen_pkg::*;
#(
  parameter int MW = 4
) (
  input  logic [MW-1:0] meta_idx,
  input  logic [MW-1:0] tup_off,
  input  logic [7:0]    in_byte,
  input  logic [15:0]   crc,
  input  logic [15:0]   atag,
  input  logic [31:0]   rtag,
  input  logic          zeroes,
  input  logic          gen,
  output logic [7:0]    byte_out
);

  logic       in_tup;
  logic [2:0] k;
  logic [7:0] tup_byte;

  always_comb begin
    in_tup = ({1'b0, meta_idx} >= {1'b0, tup_off}) &&
             ({1'b0, meta_idx} < ({1'b0, tup_off} + (MW+1)'(TUPLE_BYTES)));
    k = 3'(meta_idx - tup_off);
    unique case (k)
      3'd0: tup_byte = crc[15:8];
      3'd1: tup_byte = crc[7:0];
      3'd2: tup_byte = atag[15:8];
      3'd3: tup_byte = atag[7:0];
      3'd4: tup_byte = rtag[31:24];
      3'd5: tup_byte = rtag[23:16];
      3'd6: tup_byte = rtag[15:8];
      default: tup_byte = rtag[7:0];
    endcase
    if (zeroes) byte_out = (gen && in_tup && k >= 3'd2) ? tup_byte : 8'h00;
    else        byte_out = (gen && in_tup) ? tup_byte : in_byte;
  end

endmodule

// File: rtl/pi_tuple_gen.sv
module pi_tuple_gen
  import pi_gen_pkg::*;
#(
  parameter int DATA_BYTES = 32,
  parameter int META_BYTES = 16,
  parameter int NBLK_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cmd_zeroes,
  input  logic              cmd_gen,
  input  logic [2:0]        cmd_chk,
  input  logic [1:0]        cmd_ptype,
  input  logic              cmd_front,
  input  logic [31:0]       cmd_slba,
  input  logic [31:0]       cmd_rtag,
  input  logic [15:0]       cmd_atag,
  input  logic [NBLK_W-1:0] cmd_nblk,
  output logic              busy,
  output logic              done,
  output logic              rej,
  output logic              dnr,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              out_last
);

  localparam int BLK_TOTAL = DATA_BYTES + META_BYTES;
  localparam int PW        = $clog2(BLK_TOTAL);
  localparam int MW        = (META_BYTES > 1) ? $clog2(META_BYTES) : 1;
  localparam logic [PW-1:0] POS_LAST = PW'(BLK_TOTAL - 1);
  localparam logic [PW-1:0] POS_META = PW'(DATA_BYTES);
  localparam logic [MW-1:0] TAIL_OFF = MW'(META_BYTES - TUPLE_BYTES);

  seq_state_e        state_q;
  logic [PW-1:0]     pos_q;
  logic [NBLK_W-1:0] blk_q, nblk_q;
  logic [31:0]       rtag_q;
  logic [15:0]       atag_q;
  logic              zeroes_q, gen_q, front_q;
  prot_type_e        ptype_q;
  logic              done_q, rej_q, dnr_q;

  logic scr_reject, scr_dnr;

  pi_cmd_screen u_screen (
    .zeroes (cmd_zeroes),
    .chk    (cmd_chk),
    .ptype  (prot_type_e'(cmd_ptype)),
    .slba   (cmd_slba),
    .rtag   (cmd_rtag),
    .reject (scr_reject),
    .dnr    (scr_dnr)
  );

  logic running, start_take, fire, blk_end, meta_phase, in_prefix;
  logic [MW-1:0] meta_idx, tup_off;
  logic crc_clr, crc_en;
  logic [15:0] crc;
  logic [7:0]  meta_byte;

  assign running    = (state_q == ST_RUN);
  assign start_take = start && (state_q == ST_IDLE);
  assign meta_phase = (pos_q >= POS_META);
  assign meta_idx   = MW'(pos_q - POS_META);
  assign tup_off    = front_q ? '0 : TAIL_OFF;
  assign in_prefix  = meta_phase && (meta_idx < tup_off);

  assign out_valid = running && (zeroes_q || in_valid);
  assign in_ready  = running && !zeroes_q && out_ready;
  assign fire      = out_valid && out_ready;
  assign blk_end   = fire && (pos_q == POS_LAST);
  assign out_last  = running && (pos_q == POS_LAST);

  assign crc_clr = blk_end || start_take;
  assign crc_en  = fire && !zeroes_q && (!meta_phase || in_prefix);

  pi_crc16_acc #(.POLY(GUARD_POLY)) u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (crc_clr),
    .en    (crc_en),
    .din   (in_data),
    .crc   (crc)
  );

  pi_tuple_mux #(.MW(MW)) u_mux (
    .meta_idx (meta_idx),
    .tup_off  (tup_off),
    .in_byte  (in_data),
    .crc      (crc),
    .atag     (atag_q),
    .rtag     (rtag_q),
    .zeroes   (zeroes_q),
    .gen      (gen_q),
    .byte_out (meta_byte)
  );

  assign out_data = meta_phase ? meta_byte : in_data;
  assign busy     = running;
  assign done     = done_q;
  assign rej      = rej_q;
  assign dnr      = dnr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      pos_q    <= '0;
      blk_q    <= '0;
      nblk_q   <= '0;
      rtag_q   <= '0;
      atag_q   <= '0;
      zeroes_q <= 1'b0;
      gen_q    <= 1'b0;
      front_q  <= 1'b0;
      ptype_q  <= PT_NONE;
      done_q   <= 1'b0;
      rej_q    <= 1'b0;
      dnr_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_take) begin
        if (scr_reject) begin
          done_q <= 1'b1;
          rej_q  <= 1'b1;
          dnr_q  <= scr_dnr;
        end else begin
          state_q  <= ST_RUN;
          pos_q    <= cmd_zeroes ? POS_META : '0;
          blk_q    <= '0;
          nblk_q   <= cmd_nblk;
          rtag_q   <= cmd_rtag;
          atag_q   <= cmd_atag;
          zeroes_q <= cmd_zeroes;
          gen_q    <= cmd_gen;
          front_q  <= cmd_front;
          ptype_q  <= prot_type_e'(cmd_ptype);
        end
      end else if (running && fire) begin
        if (pos_q == POS_LAST) begin
          pos_q <= zeroes_q ? POS_META : '0;
          if (ptype_q != PT_T3) rtag_q <= rtag_q + 32'd1;
          if (blk_q == nblk_q) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            rej_q   <= 1'b0;
            dnr_q   <= 1'b0;
          end else begin
            blk_q <= blk_q + 1'b1;
          end
        end else begin
          pos_q <= pos_q + 1'b1;
        end
      end
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!out_valid && !in_ready));

  assert_ref_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_end && ptype_q != PT_T3) |=> (rtag_q == $past(rtag_q) + 32'd1));

  assert_ref_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_end && ptype_q == PT_T3) |=> $stable(rtag_q));

  assert_zero_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && zeroes_q) |=> (out_valid && $stable(out_data)));

  assert_zero_no_take_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && zeroes_q) |-> !in_ready);

  assert_done_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/pi_tuple_gen_tb.sv
`timescale 1ns/1ps
module pi_tuple_gen_tb_top;

  localparam int DB   = 32;
  localparam int MB   = 16;
  localparam int NBW  = 4;
  localparam int MAXB = 4;
  localparam int BUFN = MAXB * (DB + MB);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, cmd_zeroes = 1'b0, cmd_gen = 1'b0, cmd_front = 1'b0;
  logic [2:0] cmd_chk = '0;
  logic [1:0] cmd_ptype = '0;
  logic [31:0] cmd_slba = '0, cmd_rtag = '0;
  logic [15:0] cmd_atag = '0;
  logic [NBW-1:0] cmd_nblk = '0;
  logic busy, done, rej, dnr;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, out_valid, out_last;
  logic [7:0] out_data;

  always #10 clk = ~clk;

  pi_tuple_gen #(.DATA_BYTES(DB), .META_BYTES(MB), .NBLK_W(NBW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_zeroes(cmd_zeroes),
    .cmd_gen(cmd_gen), .cmd_chk(cmd_chk), .cmd_ptype(cmd_ptype),
    .cmd_front(cmd_front), .cmd_slba(cmd_slba), .cmd_rtag(cmd_rtag),
    .cmd_atag(cmd_atag), .cmd_nblk(cmd_nblk), .busy(busy), .done(done),
    .rej(rej), .dnr(dnr), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  logic [7:0] inb  [BUFN];
  logic [7:0] expb [BUFN];

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] b);
    logic fb;
    for (int i = 7; i >= 0; i--) begin
      fb = c[15] ^ b[i];
      c  = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h8BB7;
    end
    return c;
  endfunction

  function automatic logic [7:0] tuple_byte(input int k, input logic [15:0] g,
                                            input logic [15:0] a, input logic [31:0] r);
    logic [63:0] t;
    t = {g, a, r};
    return t[63 - 8*k -: 8];
  endfunction

  function automatic string tag_of(input bit wz, input bit gen, input int toff, input int off);
    int j;
    if (wz)  return "R10";
    if (!gen) return "R8";
    if (off < DB) return "R3";
    j = off - DB - toff;
    if (j < 0 || j > 7) return "R3";
    if (j < 2) return "R2";
    if (j < 4) return "R4";
    return "R5";
  endfunction

  task automatic build_expect(input bit wz, input bit gen, input bit fr,
                              input logic [1:0] pt, input logic [31:0] rt,
                              input logic [15:0] at, input int nb);
    int toff;
    toff = fr ? 0 : MB - 8;
    for (int b = 0; b < nb; b++) begin
      logic [15:0] c;
      logic [31:0] r;
      int base;
      logic [7:0] v;
      c = '0;
      r = (pt == 2'd3) ? rt : rt + 32'(b);
      if (wz) begin
        for (int j = 0; j < MB; j++) begin
          v = 8'h00;
          if (gen && j >= toff + 2 && j < toff + 8) v = tuple_byte(j - toff, 16'h0, at, r);
          expb[b*MB + j] = v;
        end
      end else begin
        base = b * (DB + MB);
        for (int i = 0; i < DB; i++) begin
          expb[base+i] = inb[base+i];
          c = crc_step(c, inb[base+i]);
        end
        for (int j = 0; j < MB; j++) begin
          v = inb[base+DB+j];
          if (j < toff) c = crc_step(c, v);
          if (gen && j >= toff && j < toff + 8) v = tuple_byte(j - toff, c, at, r);
          expb[base+DB+j] = v;
        end
      end
    end
  endtask

  task automatic run_cmd(input bit wz, input bit gen, input logic [2:0] ck,
                         input logic [1:0] pt, input bit fr, input logic [31:0] sl,
                         input logic [31:0] rt, input logic [15:0] at, input int nb,
                         input bit poke, input bit hammer, input string rtag_req);
    bit exp_rej, exp_dnr, stall_pend;
    int per, total_out, total_in, ii, oi, cyc, donecnt;
    logic [7:0] held;
    exp_rej = 1'b0; exp_dnr = 1'b0;
    if (wz) begin
      if (|ck) begin exp_rej = 1'b1; exp_dnr = 1'b1; end
    end else if (pt == 2'd1 && ck[2] && sl != rt) begin
      exp_rej = 1'b1; exp_dnr = 1'b1;
    end else if (pt == 2'd3 && ck[2]) begin
      exp_rej = 1'b1;
    end
    per       = wz ? MB : DB + MB;
    total_out = per * nb;
    total_in  = wz ? 0 : total_out;
    for (int i = 0; i < BUFN; i++) inb[i] = 8'($urandom);
    build_expect(wz, gen, fr, pt, rt, at, nb);

    @(negedge clk);
    cmd_zeroes = wz; cmd_gen = gen; cmd_chk = ck; cmd_ptype = pt; cmd_front = fr;
    cmd_slba = sl; cmd_rtag = rt; cmd_atag = at; cmd_nblk = NBW'(nb - 1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;

    if (exp_rej) begin
      #5;
      check(done && rej && (dnr == exp_dnr) && !out_valid && !busy, rtag_req,
            {busy, out_valid, done, rej, dnr}, {2'b00, 1'b1, 1'b1, exp_dnr});
      for (int w = 0; w < 3; w++) begin
        @(negedge clk); #5;
        check(!out_valid && !done, rtag_req, {out_valid, done}, 2'b00);
      end
      return;
    end

    ii = 0; oi = 0; cyc = 0; donecnt = 0; stall_pend = 1'b0; held = '0;
    while (oi < total_out && cyc < 5000) begin
      in_valid  = (ii < total_in) && ($urandom % 4 != 0);
      in_data   = (ii < total_in) ? inb[ii] : 8'h00;
      out_ready = hammer ? ($urandom % 4 == 0) : ($urandom % 4 != 0);
      start     = poke && (oi == total_out / 2);
      #5;
      if (done) donecnt++;
      if (stall_pend)
        check(out_valid && out_data == held, "R7", {out_valid, out_data}, {1'b1, held});
      if (wz) check(!in_ready, "R10", in_ready, 1'b0);
      else    check(in_ready == out_ready, "R7", in_ready, out_ready);
      if (out_valid && out_ready) begin
        check(out_data == expb[oi], tag_of(wz, gen, fr ? 0 : MB - 8, (oi % per) + (wz ? DB : 0)),
              out_data, expb[oi]);
        check(out_last == ((oi % per) == per - 1), "R6", out_last, ((oi % per) == per - 1));
        oi++;
      end
      stall_pend = wz && out_valid && !out_ready;
      held = out_data;
      if (in_valid && in_ready) ii++;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    #5;
    check(done && !rej && !busy && donecnt == 0, "R13", {donecnt[3:0], done, rej, busy},
          {4'd0, 3'b100});
    @(negedge clk); #5;
    check(!done && !out_valid, "R13", {done, out_valid}, 2'b00);
  endtask

  initial begin : watchdog
    int c;
    c = 0;
    while (!finished) begin
      @(posedge clk);
      c++;
      if (c > 180000 && !finished) begin
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", c, 180000);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin : main
    void'($urandom(32'd1957));
    repeat (3) @(negedge clk);
    #5;
    check(!busy && !done && !out_valid && !in_ready, "R1",
          {busy, done, out_valid, in_ready}, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk); #5;
    check(!busy && !done && !out_valid && !in_ready, "R1",
          {busy, done, out_valid, in_ready}, 4'b0000);

    // Directed corner cases.
    run_cmd(0, 1, 3'b000, 2'd1, 0, 32'h0, 32'h1000_00FE, 16'hBEEF, 2, 0, 0, "R2");
    run_cmd(0, 1, 3'b011, 2'd2, 1, 32'h5,  32'hFFFF_FFFF, 16'h1234, 3, 0, 0, "R3");
    run_cmd(0, 1, 3'b001, 2'd3, 0, 32'h9,  32'hABCD_0001, 16'h0F0F, 3, 0, 0, "R5");
    run_cmd(0, 0, 3'b000, 2'd1, 0, 32'h0,  32'h0000_0010, 16'h7777, 1, 0, 0, "R8");
    run_cmd(1, 1, 3'b000, 2'd1, 1, 32'h0,  32'h0000_0100, 16'hC0DE, 3, 0, 1, "R10");
    run_cmd(1, 1, 3'b000, 2'd3, 0, 32'h0,  32'h0000_0200, 16'hFACE, 2, 0, 1, "R10");
    run_cmd(1, 0, 3'b000, 2'd2, 0, 32'h0,  32'h0000_0300, 16'h1111, 1, 0, 0, "R10");
    run_cmd(1, 1, 3'b010, 2'd1, 0, 32'h0,  32'h0000_0300, 16'h1111, 1, 0, 0, "R9");
    run_cmd(0, 1, 3'b100, 2'd1, 0, 32'h20, 32'h0000_0021, 16'h2222, 1, 0, 0, "R11");
    run_cmd(0, 1, 3'b100, 2'd1, 0, 32'h21, 32'h0000_0021, 16'h2222, 2, 0, 0, "R11");
    run_cmd(0, 1, 3'b100, 2'd3, 1, 32'h21, 32'h0000_0021, 16'h3333, 1, 0, 0, "R12");
    run_cmd(0, 1, 3'b000, 2'd1, 0, 32'h0,  32'h0000_0400, 16'h4444, 4, 1, 1, "R13");
    run_cmd(1, 1, 3'b000, 2'd2, 0, 32'h0,  32'h0000_0500, 16'h5555, 2, 1, 0, "R13");

    // Constrained random mix.
    for (int n = 0; n < 40; n++) begin
      bit wz, gen, fr;
      logic [2:0] ck;
      logic [1:0] pt;
      logic [31:0] rt, sl;
      wz  = ($urandom % 5 == 0);
      gen = ($urandom % 5 != 0);
      fr  = $urandom % 2;
      pt  = 2'($urandom);
      ck  = ($urandom % 4 == 0) ? 3'($urandom) : 3'b000;
      rt  = $urandom;
      sl  = ($urandom % 2) ? rt : $urandom;
      run_cmd(wz, gen, ck, pt, fr, sl, rt, 16'($urandom), 1 + ($urandom % MAXB),
              ($urandom % 8 == 0), ($urandom % 3 == 0), "R11");
    end

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule